// File: doc/BRIEF.md
# BCD Calendar Counter

This block keeps wall-clock time and a calendar date in packed binary-coded decimal. It is advanced by a stream of sub-second pulses on `tickIn`. An internal phase counter divides these pulses by `SUB_DIV`, so every `SUB_DIV`-th accepted pulse moves the time forward by one second. The seconds then ripple into minutes, hours, day of month, weekday, month and year.

Month lengths are corrected automatically. February gets a 29th day in years whose two-digit value is a multiple of four. The hour field runs either on a 24-hour dial or on a 12-hour dial with a PM indicator. A century bit changes state every time the year passes from 99 to 00.

Software presets any field through a single-cycle write port and reads any field back through a combinational read port. The 12-hour/24-hour selection and the century bit share one control register. Changing the hour format does not convert the stored hour, so software rewrites the hour after switching.

Top module: `bcd_calendar_counter`

## Requirements
- R1: After reset the read port returns seconds 0x00, minutes 0x00, hours 0x00, day 0x01, weekday 0x00, month 0x01, year 0x00 and control 0x00 (24-hour format, century bit clear).
- R2: Each accepted `tickIn` pulse advances the phase counter. The `SUB_DIV`-th accepted pulse advances the seconds by one in BCD (for example 0x09 becomes 0x10), and the seconds stay unchanged before that pulse.
- R3: Seconds pass from 0x59 to 0x00 and advance the minutes. Minutes pass from 0x59 to 0x00 and advance the hour. Minutes change on a second step only when the seconds are 0x59.
- R4: In 24-hour format the hour occupies bits 5:0 and counts 0x00 to 0x23. Passing from 0x23 to 0x00 advances the day.
- R5: In 12-hour format the hour digits occupy bits 4:0 and the PM flag is bit 5. The digits count 0x12, 0x01 … 0x11 and back to 0x12. The PM flag toggles only on the 11-to-12 step, and the day advances when 11 PM becomes 12 AM.
- R6: The day of month wraps to 0x01 after 0x30 in months 0x04, 0x06, 0x09 and 0x11, and after 0x31 in the other months except February, advancing the month.
- R7: February ends after day 0x28, or after day 0x29 when the BCD year is a multiple of four (0x00 included).
- R8: The weekday advances together with every day-of-month step and counts 0x00 to 0x06, then wraps to 0x00.
- R9: The month passes from 0x12 to 0x01 and advances the year. The year passes from 0x99 to 0x00 and toggles the century bit, which is bit 7 of the control register.
- R10: A write takes priority: a `tickIn` pulse in a write cycle is discarded entirely. A write to the seconds clears the phase counter, so a further `SUB_DIV` accepted pulses are needed before the next second step.
- R11: Addresses are 0 seconds, 1 minutes, 2 hours, 3 day, 4 weekday, 5 month, 6 year and 7 control (bit 0 = 12-hour format, bit 7 = century). Written data is masked to 0x7F, 0x7F, 0x3F, 0x3F, 0x07, 0x1F, 0xFF and 0x81 respectively.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tickIn | input | 1 | Sub-second pulse; every `SUB_DIV`-th accepted pulse is one second |
| wrEn | input | 1 | Write strobe for one field |
| wrAddr | input | 3 | Field address for a write |
| wrData | input | 8 | Write data (BCD, masked per field) |
| rdAddr | input | 3 | Field address for a read |
| rdData | output | 8 | Contents of the addressed field |

## Verification
Seeded random stimulus mixes dense tick bursts, idle cycles, writes that coincide with ticks, and presets biased toward the last value of each field. Mixing dense and sparse bursts separates phase-counter errors from carry-chain errors. Presets at 59 seconds, 59 minutes, 11 or 23 hours and the last day of the month push single second steps through every carry path. Directed cases isolate specific confusions:
- April 30 against January 30 shows whether month lengths are decoded correctly.
- February 28 in years 0x23, 0x24 and 0x00 tells the leap rule apart from a plain 28-day month.
- 11 AM, 11 PM and 12 in 12-hour format separate PM toggling from the day carry.
- December 31 of year 99 exercises the century bit.
- A write coinciding with a tick, and a seconds write in the middle of a phase, show that the discarded tick and the cleared phase are handled separately.

// File: rtl/cal_pkg.sv
package cal_pkg;

  localparam int NUM_FIELDS = 7;
  localparam int ADDR_W     = 3;

  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DAY  = 3;
  localparam int F_WDAY = 4;
  localparam int F_MON  = 5;
  localparam int F_YEAR = 6;

  localparam logic [ADDR_W-1:0] CTRL_ADDR = 3'd7;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_FIELDS-1:0] inc;
    logic [NUM_FIELDS-1:0] wrap;
    logic                  flipPm;
    logic                  flipCentury;
  } stepT;

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  function automatic logic [7:0] fieldMask(input int idx);
    logic [7:0] m;
    case (idx)
      F_SEC, F_MIN: m = 8'h7F;
      F_HOUR:       m = 8'h3F;
      F_DAY:        m = 8'h3F;
      F_WDAY:       m = 8'h07;
      F_MON:        m = 8'h1F;
      default:      m = 8'hFF;
    endcase
    return m;
  endfunction

  function automatic logic [7:0] resetValue(input int idx);
    return (idx == F_DAY || idx == F_MON) ? 8'h01 : 8'h00;
  endfunction

  // value taken on wrap for fields without special handling
  function automatic logic [7:0] wrapValue(input int idx);
    return (idx == F_DAY || idx == F_MON) ? 8'h01 : 8'h00;
  endfunction

  // (10*t + o) mod 4 == (2*t + o) mod 4
  function automatic logic isLeapYear(input logic [7:0] yearBcd);
    logic [4:0] s;
    s = {yearBcd[7:4], 1'b0} + {1'b0, yearBcd[3:0]};
    return (s[1:0] == 2'b00);
  endfunction

  function automatic logic [7:0] lastDay(input logic [7:0] monBcd, input logic [7:0] yearBcd);
    logic [7:0] d;
    case (monBcd)
      8'h02:                      d = isLeapYear(yearBcd) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: d = 8'h30;
      default:                    d = 8'h31;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/cal_ctrl.sv
module cal_ctrl
  import cal_pkg::*;
#(
  parameter int SUB_DIV = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tickIn,
  input  logic                       wrEn,
  input  logic [ADDR_W-1:0]          wrAddr,
  input  logic [NUM_FIELDS-1:0][7:0] fieldsQ,
  input  logic                       mode12Q,
  output logic                       secondStep,
  output stepT                       step
);

  localparam int PH_W = (SUB_DIV > 1) ? $clog2(SUB_DIV) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(SUB_DIV - 1);

  logic [PH_W-1:0] phaseQ;
  logic            acceptTick;
  logic            secWrite;

  assign acceptTick = tickIn && !wrEn;
  assign secWrite   = wrEn && (wrAddr == ADDR_W'(F_SEC));
  assign secondStep = acceptTick && (phaseQ == PH_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)          phaseQ <= '0;
    else if (secWrite)   phaseQ <= '0;
    else if (acceptTick) phaseQ <= (phaseQ == PH_LAST) ? '0 : phaseQ + 1'b1;
  end

  // field limit decode
  logic [7:0] hourQ;
  logic       secMax, minMax, hourMax24, hourIs12, hourIs11, pmQ;
  logic       dayMax, wdayMax, monMax, yearMax;
  logic       dayCarry;

  assign hourQ     = fieldsQ[F_HOUR];
  assign secMax    = fieldsQ[F_SEC]  == 8'h59;
  assign minMax    = fieldsQ[F_MIN]  == 8'h59;
  assign hourMax24 = hourQ[5:0]      == 6'h23;
  assign hourIs12  = hourQ[4:0]      == 5'h12;
  assign hourIs11  = hourQ[4:0]      == 5'h11;
  assign pmQ       = hourQ[5];
  assign dayMax    = fieldsQ[F_DAY]  == lastDay(fieldsQ[F_MON], fieldsQ[F_YEAR]);
  assign wdayMax   = fieldsQ[F_WDAY] == 8'h06;
  assign monMax    = fieldsQ[F_MON]  == 8'h12;
  assign yearMax   = fieldsQ[F_YEAR] == 8'h99;

  always_comb begin
    step = '0;
    step.inc[F_SEC]   = secondStep;
    step.wrap[F_SEC]  = secMax;
    step.inc[F_MIN]   = secondStep && secMax;
    step.wrap[F_MIN]  = minMax;
    step.inc[F_HOUR]  = step.inc[F_MIN] && minMax;
    step.wrap[F_HOUR] = mode12Q ? hourIs12 : hourMax24;
    step.flipPm       = step.inc[F_HOUR] && mode12Q && hourIs11;
    dayCarry          = step.inc[F_HOUR] && (mode12Q ? (hourIs11 && pmQ) : hourMax24);
    step.inc[F_DAY]   = dayCarry;
    step.wrap[F_DAY]  = dayMax;
    step.inc[F_WDAY]  = dayCarry;
    step.wrap[F_WDAY] = wdayMax;
    step.inc[F_MON]   = dayCarry && dayMax;
    step.wrap[F_MON]  = monMax;
    step.inc[F_YEAR]  = step.inc[F_MON] && monMax;
    step.wrap[F_YEAR] = yearMax;
    step.flipCentury  = step.inc[F_YEAR] && yearMax;
  end

endmodule

// File: rtl/cal_datapath.sv
module cal_datapath
  import cal_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  stepT                       step,
  input  logic                       wrEn,
  input  logic [ADDR_W-1:0]          wrAddr,
  input  logic [7:0]                 wrData,
  output logic [NUM_FIELDS-1:0][7:0] fieldsQ,
  output logic                       mode12Q,
  output logic                       centuryQ
);

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : gField
    logic fieldWr;
    assign fieldWr = wrEn && (wrAddr == ADDR_W'(g));

    if (g == F_HOUR) begin : gHour
      logic [7:0] digitsNext;
      assign digitsNext = bcdInc({3'b000, fieldsQ[g][4:0]});
      always_ff @(posedge clk) begin
        if (!rst_n)             fieldsQ[g] <= resetValue(g);
        else if (fieldWr)       fieldsQ[g] <= wrData & fieldMask(g);
        else if (step.inc[g]) begin
          if (mode12Q) begin
            if (step.wrap[g]) fieldsQ[g] <= {2'b00, fieldsQ[g][5], 5'h01};
            else              fieldsQ[g] <= {2'b00, fieldsQ[g][5] ^ step.flipPm, digitsNext[4:0]};
          end else begin
            fieldsQ[g] <= step.wrap[g] ? 8'h00 : bcdInc(fieldsQ[g]);
          end
        end
      end
    end else begin : gPlain
      always_ff @(posedge clk) begin
        if (!rst_n)           fieldsQ[g] <= resetValue(g);
        else if (fieldWr)     fieldsQ[g] <= wrData & fieldMask(g);
        else if (step.inc[g]) fieldsQ[g] <= step.wrap[g] ? wrapValue(g) : bcdInc(fieldsQ[g]);
      end
    end
  end

  logic ctrlWr;
  assign ctrlWr = wrEn && (wrAddr == CTRL_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode12Q  <= 1'b0;
      centuryQ <= 1'b0;
    end else if (ctrlWr) begin
      mode12Q  <= wrData[0];
      centuryQ <= wrData[7];
    end else if (step.flipCentury) begin
      centuryQ <= ~centuryQ;
    end
  end

endmodule

// File: rtl/bcd_calendar_counter.sv
module bcd_calendar_counter
  import cal_pkg::*;
#(
  parameter int SUB_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tickIn,
  input  logic        wrEn,
  input  logic [2:0]  wrAddr,
  input  logic [7:0]  wrData,
  input  logic [2:0]  rdAddr,
  output logic [7:0]  rdData
);

  logic [NUM_FIELDS-1:0][7:0] fieldsQ;
  logic                       mode12Q;
  logic                       centuryQ;
  logic                       secondStep;
  stepT                       step;

  cal_ctrl #(.SUB_DIV(SUB_DIV)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tickIn     (tickIn),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .fieldsQ    (fieldsQ),
    .mode12Q    (mode12Q),
    .secondStep (secondStep),
    .step       (step)
  );

  cal_datapath dp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .fieldsQ  (fieldsQ),
    .mode12Q  (mode12Q),
    .centuryQ (centuryQ)
  );

  always_comb begin
    rdData = {centuryQ, 6'b000000, mode12Q};
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (rdAddr == i[2:0]) rdData = fieldsQ[i];
    end
  end

endmodule

// File: rtl/cal_checker.sv
module cal_checker
  import cal_pkg::*;
(
  input logic                       clk,
  input logic                       rst_n,
  input logic                       wrEn,
  input logic [2:0]                 wrAddr,
  input logic [7:0]                 wrData,
  input logic                       secondStep,
  input logic [NUM_FIELDS-1:0][7:0] fieldsQ,
  input logic                       mode12Q,
  input logic                       centuryQ
);

  assert_sec_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (secondStep && fieldsQ[F_SEC] == 8'h59) |=> fieldsQ[F_SEC] == 8'h00);

  assert_min_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (secondStep && fieldsQ[F_SEC] != 8'h59) |=> fieldsQ[F_MIN] == $past(fieldsQ[F_MIN]));

  assert_pm_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode12Q && !$past(wrEn) && fieldsQ[F_HOUR][5] != $past(fieldsQ[F_HOUR][5]))
      |-> fieldsQ[F_HOUR][4:0] == 5'h12);

  assert_wday_with_day_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wrEn) && fieldsQ[F_WDAY] != $past(fieldsQ[F_WDAY]))
      |-> fieldsQ[F_DAY] != $past(fieldsQ[F_DAY]));

  assert_century_flip_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wrEn) && centuryQ != $past(centuryQ))
      |-> ($past(fieldsQ[F_YEAR]) == 8'h99 && fieldsQ[F_YEAR] == 8'h00));

  assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && wrAddr == 3'd1) |=> fieldsQ[F_MIN] == ($past(wrData) & 8'h7F));

  assert_tick_dropped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && wrAddr != 3'd0) |=> fieldsQ[F_SEC] == $past(fieldsQ[F_SEC]));

endmodule

bind bcd_calendar_counter cal_checker chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .wrEn       (wrEn),
  .wrAddr     (wrAddr),
  .wrData     (wrData),
  .secondStep (secondStep),
  .fieldsQ    (fieldsQ),
  .mode12Q    (mode12Q),
  .centuryQ   (centuryQ)
);

// File: tb/bcd_calendar_counter_tb_top.sv
`timescale 1ns/1ps
module bcd_calendar_counter_tb_top;

  localparam int SUB_DIV = 4;
  localparam realtime CLK_PERIOD = 4.0;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tickIn = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [2:0] rdAddr = '0;
  logic [7:0] rdData;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_calendar_counter #(.SUB_DIV(SUB_DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .tickIn(tickIn), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData)
  );

  // ---------------- reference model ----------------
  logic [7:0] m [0:6];
  bit mMode, mCent;
  int mPhase;

  function automatic int b2i(input logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  function automatic logic [7:0] i2b(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic int dim(input int mon, input int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  task automatic modelDay();
    int d, mo, y;
    m[4] = i2b((b2i(m[4]) + 1) % 7);
    d = b2i(m[3]) + 1; mo = b2i(m[5]); y = b2i(m[6]);
    if (d > dim(mo, y)) begin
      d = 1; mo++;
      if (mo > 12) begin
        mo = 1; y++;
        if (y == 100) begin y = 0; mCent = !mCent; end
      end
    end
    m[3] = i2b(d); m[5] = i2b(mo); m[6] = i2b(y);
  endtask

  task automatic modelHour();
    int h; bit pm; logic [7:0] b;
    if (mMode) begin
      h = b2i({3'b000, m[2][4:0]}); pm = m[2][5];
      if (h == 12) h = 1;
      else if (h == 11) begin
        h = 12; pm = !pm;
        if (!pm) modelDay();
      end else h++;
      b = i2b(h);
      m[2] = {2'b00, pm, b[4:0]};
    end else begin
      h = b2i({2'b00, m[2][5:0]}) + 1;
      if (h == 24) begin h = 0; modelDay(); end
      m[2] = i2b(h);
    end
  endtask

  task automatic modelSecond();
    int s, mi;
    s = b2i(m[0]) + 1;
    if (s == 60) begin
      s = 0; mi = b2i(m[1]) + 1;
      if (mi == 60) begin mi = 0; modelHour(); end
      m[1] = i2b(mi);
    end
    m[0] = i2b(s);
  endtask

  function automatic logic [7:0] maskOf(input int a);
    case (a)
      0, 1: return 8'h7F;
      2, 3: return 8'h3F;
      4: return 8'h07;
      5: return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] expRead(input int a);
    if (a == 7) return {mCent, 6'b000000, mMode};
    return m[a];
  endfunction

  // ---------------- driving ----------------
  task automatic doCycle(input bit tk, input bit we, input int a, input logic [7:0] d);
    tickIn = tk; wrEn = we; wrAddr = 3'(a); wrData = d;
    @(posedge clk);
    if (we) begin
      if (a == 7) begin mMode = d[0]; mCent = d[7]; end
      else begin
        m[a] = d & maskOf(a);
        if (a == 0) mPhase = 0;
      end
    end else if (tk) begin
      mPhase++;
      if (mPhase == SUB_DIV) begin mPhase = 0; modelSecond(); end
    end
    @(negedge clk);
    tickIn = 1'b0; wrEn = 1'b0;
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    doCycle(1'b0, 1'b1, a, d);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) doCycle(1'b1, 1'b0, 0, 8'h00);
  endtask

  task automatic check(input int a, input logic [7:0] exp, input string tag);
    rdAddr = 3'(a);
    #0.5;
    checks++;
    if (rdData !== exp) begin
      fails++;
      $display("FAIL %s addr %0d actual 0x%02h expected 0x%02h", tag, a, rdData, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    for (int a = 0; a < 8; a++) check(a, expRead(a), tag);
  endtask

  task automatic setClock(input logic [7:0] h, input logic [7:0] mi, input logic [7:0] s);
    wr(2, h); wr(1, mi); wr(0, s);
  endtask

  task automatic setDate(input logic [7:0] y, input logic [7:0] mo, input logic [7:0] d, input logic [7:0] w);
    wr(6, y); wr(5, mo); wr(3, d); wr(4, w);
  endtask

  // ---------------- random helpers ----------------
  function automatic int pick(input int lo, input int hi, input int edgeV);
    if ($urandom_range(3, 0) == 0) return edgeV;
    return int'($urandom_range(hi, lo));
  endfunction

  task automatic randomDate();
    int y, mo, d;
    y  = pick(0, 99, 99);
    mo = ($urandom_range(3, 0) == 0) ? 2 : pick(1, 12, 12);
    d  = ($urandom_range(1, 0) == 0) ? dim(mo, y) : int'($urandom_range(dim(mo, y), 1));
    setDate(i2b(y), i2b(mo), i2b(d), i2b(int'($urandom_range(6, 0))));
  endtask

  task automatic randomTime();
    logic [7:0] h;
    if ($urandom_range(3, 0) == 0) wr(7, {mCent, 6'b000000, 1'($urandom_range(1, 0))});
    if (mMode) begin
      h = i2b(pick(1, 12, 11));
      h[5] = 1'($urandom_range(1, 0));
    end else h = i2b(pick(0, 23, 23));
    setClock(h, i2b(pick(0, 59, 59)), i2b(pick(0, 59, 59)));
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired before end of test");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // ---------------- main ----------------
  initial begin
    int r;
    m[0] = 8'h00; m[1] = 8'h00; m[2] = 8'h00; m[3] = 8'h01;
    m[4] = 8'h00; m[5] = 8'h01; m[6] = 8'h00;
    mMode = 0; mCent = 0; mPhase = 0;
    void'($urandom(32'h5EED_0042));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checkAll("R1 reset values");

    // R2: phase divides by SUB_DIV, BCD increment
    tick(SUB_DIV - 1);
    check(0, 8'h00, "R2 no step before last pulse");
    tick(1);
    check(0, 8'h01, "R2 step on last pulse");
    wr(0, 8'h09);
    tick(SUB_DIV);
    check(0, 8'h10, "R2 BCD digit carry");

    // R3: sec/min carries
    setClock(8'h05, 8'h59, 8'h59);
    tick(SUB_DIV);
    check(0, 8'h00, "R3 seconds wrap");
    check(1, 8'h00, "R3 minutes wrap");
    check(2, 8'h06, "R3 hour advance");

    // R4: 24-hour midnight
    setDate(8'h23, 8'h01, 8'h10, 8'h02);
    setClock(8'h23, 8'h59, 8'h59);
    tick(SUB_DIV);
    check(2, 8'h00, "R4 hour 23 to 00");
    check(3, 8'h11, "R4 day advance");

    // R5: 12-hour format
    wr(7, 8'h01);
    setClock(8'h11, 8'h59, 8'h59);
    tick(SUB_DIV);
    check(2, 8'h32, "R5 11 AM to 12 PM");
    check(3, 8'h11, "R5 no day advance at noon");
    setClock(8'h32, 8'h59, 8'h59);
    tick(SUB_DIV);
    check(2, 8'h21, "R5 12 PM to 1 PM");
    setClock(8'h31, 8'h59, 8'h59);
    tick(SUB_DIV);
    check(2, 8'h12, "R5 11 PM to 12 AM");
    check(3, 8'h12, "R5 day advance at midnight");
    checkAll("R5 model");
    wr(7, 8'h00);

    // R6: month lengths
    setDate(8'h23, 8'h04, 8'h30, 8'h03);
    setClock(8'h23, 8'h59, 8'h59);
    tick(SUB_DIV);
    check(3, 8'h01, "R6 April 30 wraps");
    check(5, 8'h05, "R6 month advance");
    setDate(8'h23, 8'h01, 8'h30, 8'h03);
    setClock(8'h23, 8'h59, 8'h59);
    tick(SUB_DIV);
    check(3, 8'h31, "R6 January has 31");

    // R7: February
    setDate(8'h23, 8'h02, 8'h28, 8'h00);
    setClock(8'h23, 8'h59, 8'h59);
    tick(SUB_DIV);
    check(5, 8'h03, "R7 non-leap Feb 28 ends");
    setDate(8'h24, 8'h02, 8'h28, 8'h00);
    setClock(8'h23, 8'h59, 8'h59);
    tick(SUB_DIV);
    check(3, 8'h29, "R7 leap year Feb 29");
    setClock(8'h23, 8'h59, 8'h59);
    tick(SUB_DIV);
    check(3, 8'h01, "R7 leap Feb 29 ends");
    check(5, 8'h03, "R7 leap Feb 29 month");
    setDate(8'h00, 8'h02, 8'h28, 8'h00);
    setClock(8'h23, 8'h59, 8'h59);
    tick(SUB_DIV);
    check(3, 8'h29, "R7 year 00 is leap");

    // R8: weekday wrap
    setDate(8'h10, 8'h03, 8'h05, 8'h06);
    setClock(8'h23, 8'h59, 8'h59);
    tick(SUB_DIV);
    check(4, 8'h00, "R8 weekday 6 wraps to 0");

    // R9: year and century
    setDate(8'h99, 8'h12, 8'h31, 8'h01);
    setClock(8'h23, 8'h59, 8'h59);
    tick(SUB_DIV);
    check(5, 8'h01, "R9 month 12 wraps");
    check(6, 8'h00, "R9 year 99 wraps");
    check(7, 8'h80, "R9 century bit set");
    setDate(8'h99, 8'h12, 8'h31, 8'h01);
    setClock(8'h23, 8'h59, 8'h59);
    tick(SUB_DIV);
    check(7, 8'h00, "R9 century bit toggles back");

    // R10: write priority and phase clear
    wr(0, 8'h20);
    tick(2);
    doCycle(1'b1, 1'b1, 1, 8'h07);
    check(1, 8'h07, "R10 write lands with tick");
    tick(SUB_DIV - 3);
    check(0, 8'h20, "R10 tick in write cycle dropped");
    tick(1);
    check(0, 8'h21, "R10 step after dropped tick");
    tick(SUB_DIV - 1);
    wr(0, 8'h40);
    tick(SUB_DIV - 1);
    check(0, 8'h40, "R10 seconds write clears phase");
    tick(1);
    check(0, 8'h41, "R10 step after cleared phase");

    // R11: address map and masks
    wr(4, 8'hFF);
    check(4, 8'h07, "R11 weekday mask");
    wr(1, 8'hFF);
    check(1, 8'h7F, "R11 minutes mask");
    wr(7, 8'hFF);
    check(7, 8'h81, "R11 control layout");
    wr(7, 8'h00);
    wr(4, 8'h03); wr(1, 8'h15);
    checkAll("R11 full map");

    // random phase
    for (int op = 0; op < 3000; op++) begin
      r = int'($urandom_range(99, 0));
      if (r < 60)      tick(1);
      else if (r < 70) doCycle(1'b0, 1'b0, 0, 8'h00);
      else if (r < 80) doCycle(1'b1, 1'b1, int'($urandom_range(1, 0)), i2b(pick(0, 59, 59)));
      else if (r < 88) randomDate();
      else             randomTime();
      if (op % 4 == 0) checkAll("R2 R3 R8 random");
    end
    checkAll("R9 random final");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule